// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block takes range maintenance work off a processor. A requester gives a start address, an end address and an operation: invalidate, clean, or clean-and-invalidate. The block then walks the range line by line and writes one command per line to the command port of a cache controller. Before each command it waits until the controller's busy flag for that kind of command is low. When the lines are done, it waits for the last one to finish, writes a sync command and waits for the sync to complete. Only then does it pulse the acknowledge. A clean or clean-and-invalidate whose range covers at least the whole cache does not walk the lines. It sends one command that names every way.

The walk is cut into blocks of at most `CHUNK_BYTES`. Between two blocks the block drops its port-ownership flag for one cycle, so an arbiter in front of the controller can give the port to someone else. For an invalidate, a line that the range covers only in part is cleaned and invalidated instead of discarded, so bytes outside the range keep their data.

The state machine has these states:

- **IDLE**: waits for a request.
- **HEAD**: the edge flushes of an invalidate.
- **SETUP**: computes the end of the next block.
- **BODY**: the per-line commands.
- **GAP**: the one-cycle release between blocks.
- **DRAIN**: waits for the last line operation.
- **SYNC_ISSUE** and **SYNC_WAIT**: write the sync and wait for it.
- **WAY_ISSUE** and **WAY_WAIT**: the whole-cache command and its wait.
- **DONE**: the acknowledge cycle.

The transitions are:

- IDLE to WAY_ISSUE when the whole-cache test holds.
- IDLE to HEAD for an invalidate.
- IDLE to SETUP for any other operation.
- HEAD to SETUP once no edge flush is pending.
- SETUP to BODY when lines remain, and SETUP to DRAIN when none remain.
- BODY to GAP when the block is done and more blocks follow.
- BODY to DRAIN after the last block.
- GAP to SETUP.
- DRAIN to SYNC_ISSUE once the operation's busy flag is low.
- SYNC_ISSUE to SYNC_WAIT.
- SYNC_WAIT to DONE once the sync busy flag is low.
- WAY_ISSUE to WAY_WAIT.
- WAY_WAIT to SYNC_ISSUE once every masked way bit is low.
- DONE to IDLE.

Top module: `cache_range_seq`

## Requirements
- R1: After reset the block is idle: `cmd_valid`, `req_ack` and `port_hold` are low. Each accepted request produces exactly one `req_ack` pulse, one cycle wide.
- R2: While a request is in progress, `req_valid`, `req_op`, `req_start` and `req_end` are ignored. The commands follow the request that was accepted.
- R3: For operation 1 (clean) or 2 (clean-and-invalidate), the whole-cache path is taken when `req_end >= req_start` and `req_end - req_start >= CACHE_BYTES`. It issues one command of kind 4 (clean ways) or 5 (clean-and-invalidate ways), with `cmd_data` equal to the all-ways mask. It then waits until `way_busy & mask` is zero, and then issues the sync.
- R4: For operation 1 or 2 without the whole-cache path, the start is aligned down to a multiple of `LINE_BYTES`. A line command goes out for each line address `a` with `a < req_end`, in rising order. The kind is 1 (clean line) for operation 1 and 2 (clean-and-invalidate line) for operation 2.
- R5: For operation 0 (invalidate) with an unaligned start, the first command is kind 2 on the aligned-down start line. The walk then begins one line higher.
- R6: For operation 0 with an unaligned end, a kind 2 command goes to the aligned-down end line, after any start-edge command. Kind 0 (invalidate line) commands then cover the lines from the walk start up to, but not including, that aligned end. With an aligned end, the kind 0 commands run up to `req_end`, exclusive.
- R7: A request whose line walk is empty issues no line command of kind 0 or 1, and no kind 2 beyond any R5/R6 edge flush. It still issues the sync and acknowledges.
- R8: A line command of kind k (0, 1 or 2) is never issued while `line_busy[k]` is high.
- R9: The walk runs in blocks. Each block is at most `CHUNK_BYTES` measured from the block's first line address. Between consecutive blocks `port_hold` is low for exactly one cycle. It is never low at any other time within a request.
- R10: The sync command (kind 3, data 0) is the last command of every request. It is issued only after the operation's own busy flag (line or ways) reads low. `req_ack` follows only after `sync_busy` reads low.
- R11: Operation code 3 behaves exactly as operation 2.
- R12: Every line command carries an address with its low log2(`LINE_BYTES`) bits at zero. `cmd_valid` is only ever high while `port_hold` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, taken when idle |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 or 3 clean-and-invalidate |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Byte address just past the range |
| req_ack | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Command written to the controller this cycle |
| cmd_kind | output | 3 | 0 inv line, 1 clean line, 2 clean+inv line, 3 sync, 4 clean ways, 5 clean+inv ways |
| cmd_data | output | ADDR_W | Line address, way mask or zero for sync |
| port_hold | output | 1 | Block owns the command port |
| line_busy | input | 3 | Busy flag per line command kind 0..2 |
| sync_busy | input | 1 | Sync in progress |
| way_busy | input | NUM_WAYS | Per-way busy of a whole-cache operation |

## Verification
The assertions check the properties that hold on every cycle: the single-cycle acknowledge, that no line command goes out under its busy flag, line alignment, the all-ways mask on the whole-cache command, that commands appear only while the port is held, the one-cycle length of a release, and that a sync comes before each acknowledge. What only the bench scenarios can show is the exact command list for each range: the edge flushes of an invalidate, the choice of the whole-cache path at the size boundary, the empty and reversed ranges, the count of block releases, and that changes to the request in mid-flight are ignored. The bench checks these against lists that it computes from the addresses in a sweep over start offsets and lengths for every operation.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;

    typedef enum logic [2:0] {
        CMD_INV_LINE   = 3'd0,
        CMD_CLEAN_LINE = 3'd1,
        CMD_CLINV_LINE = 3'd2,
        CMD_SYNC       = 3'd3,
        CMD_CLEAN_WAYS = 3'd4,
        CMD_CLINV_WAYS = 3'd5
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD,
        ST_SETUP,
        ST_BODY,
        ST_GAP,
        ST_DRAIN,
        ST_SYNC_ISSUE,
        ST_SYNC_WAIT,
        ST_WAY_ISSUE,
        ST_WAY_WAIT,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] OP_INVAL = 2'd0;
    localparam logic [1:0] OP_CLEAN = 2'd1;

    // per-line command kind used by an operation code
    function automatic cmd_kind_e line_kind_of(input logic [1:0] op);
        cmd_kind_e k;
        case (op)
            2'd0:    k = CMD_INV_LINE;
            2'd1:    k = CMD_CLEAN_LINE;
            default: k = CMD_CLINV_LINE;
        endcase
        return k;
    endfunction

    // whole-cache command kind used by an operation code
    function automatic cmd_kind_e way_kind_of(input logic [1:0] op);
        return (op == OP_CLEAN) ? CMD_CLEAN_WAYS : CMD_CLINV_WAYS;
    endfunction

endpackage

// File: rtl/crs_range_calc.sv
`timescale 1ns/1ps
module crs_range_calc #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 4096,
    parameter int CACHE_BYTES = 262144
) (
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic [ADDR_W:0]   cur,
    input  logic [ADDR_W:0]   lim,
    output logic [ADDR_W:0]   start_line,
    output logic              start_part,
    output logic              end_part,
    output logic [ADDR_W:0]   lim_line,
    output logic              whole_hit,
    output logic [ADDR_W:0]   chunk_end
);
    localparam int            OFS_W     = $clog2(LINE_BYTES);
    localparam logic [ADDR_W:0] LINE_MASK = (ADDR_W+1)'(LINE_BYTES - 1);
    localparam logic [ADDR_W:0] CHUNK_SZ  = (ADDR_W+1)'(CHUNK_BYTES);
    localparam logic [ADDR_W:0] CACHE_SZ  = (ADDR_W+1)'(CACHE_BYTES);

    logic [ADDR_W:0] span;
    logic [ADDR_W:0] remain;

    assign start_line = {1'b0, req_start} & ~LINE_MASK;
    assign start_part = |req_start[OFS_W-1:0];
    assign end_part   = |req_end[OFS_W-1:0];
    assign lim_line   = lim & ~LINE_MASK;

    // range size test for the whole-cache shortcut
    assign span      = {1'b0, req_end} - {1'b0, req_start};
    assign whole_hit = (req_end >= req_start) && (span >= CACHE_SZ);

    // block end: at most one chunk past the current line
    assign remain    = lim - cur;
    assign chunk_end = cur + ((remain > CHUNK_SZ) ? CHUNK_SZ : remain);

endmodule

// File: rtl/crs_busy_mux.sv
`timescale 1ns/1ps
module crs_busy_mux
    import crs_pkg::*;
#(
    parameter int NUM_WAYS = 8
) (
    input  cmd_kind_e           kind,
    input  logic [2:0]          line_busy,
    input  logic                sync_busy,
    input  logic [NUM_WAYS-1:0] way_busy,
    output logic                busy
);
    localparam logic [NUM_WAYS-1:0] WAY_ALL = '1;

    always_comb begin
        case (kind)
            CMD_INV_LINE, CMD_CLEAN_LINE, CMD_CLINV_LINE: busy = line_busy[kind[1:0]];
            CMD_SYNC:                                     busy = sync_busy;
            default:                                      busy = |(way_busy & WAY_ALL);
        endcase
    end

endmodule

// File: rtl/cache_range_seq.sv
`timescale 1ns/1ps
module cache_range_seq
    import crs_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 4096,
    parameter int CACHE_BYTES = 262144,
    parameter int NUM_WAYS    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_start,
    input  logic [ADDR_W-1:0]   req_end,
    output logic                req_ack,
    output logic                cmd_valid,
    output logic [2:0]          cmd_kind,
    output logic [ADDR_W-1:0]   cmd_data,
    output logic                port_hold,
    input  logic [2:0]          line_busy,
    input  logic                sync_busy,
    input  logic [NUM_WAYS-1:0] way_busy
);
    localparam logic [ADDR_W:0]     LINE_STEP = (ADDR_W+1)'(LINE_BYTES);
    localparam logic [NUM_WAYS-1:0] WAY_MASK  = '1;

    seq_state_e      state_q, state_d;
    logic [1:0]      op_q, op_d;
    logic [ADDR_W:0] cur_q, cur_d;
    logic [ADDR_W:0] lim_q, lim_d;
    logic [ADDR_W:0] blk_q, blk_d;
    logic            head_q, head_d;
    logic            tail_q, tail_d;

    logic [ADDR_W:0] start_line, lim_line, chunk_end;
    logic            start_part, end_part, whole_hit;
    cmd_kind_e       wait_kind;
    logic            busy;
    logic            body_more;

    crs_range_calc #(
        .ADDR_W      (ADDR_W),
        .LINE_BYTES  (LINE_BYTES),
        .CHUNK_BYTES (CHUNK_BYTES),
        .CACHE_BYTES (CACHE_BYTES)
    ) u_calc (
        .req_start  (req_start),
        .req_end    (req_end),
        .cur        (cur_q),
        .lim        (lim_q),
        .start_line (start_line),
        .start_part (start_part),
        .end_part   (end_part),
        .lim_line   (lim_line),
        .whole_hit  (whole_hit),
        .chunk_end  (chunk_end)
    );

    crs_busy_mux #(
        .NUM_WAYS (NUM_WAYS)
    ) u_busy (
        .kind      (wait_kind),
        .line_busy (line_busy),
        .sync_busy (sync_busy),
        .way_busy  (way_busy),
        .busy      (busy)
    );

    assign body_more = cur_q < blk_q;

    // command kind the current state issues or waits on
    always_comb begin
        unique case (state_q)
            ST_HEAD:                     wait_kind = CMD_CLINV_LINE;
            ST_WAY_ISSUE, ST_WAY_WAIT:   wait_kind = way_kind_of(op_q);
            ST_SYNC_ISSUE, ST_SYNC_WAIT: wait_kind = CMD_SYNC;
            default:                     wait_kind = line_kind_of(op_q);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_INVAL;
            cur_q   <= '0;
            lim_q   <= '0;
            blk_q   <= '0;
            head_q  <= 1'b0;
            tail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            cur_q   <= cur_d;
            lim_q   <= lim_d;
            blk_q   <= blk_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
        end
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_kind  = wait_kind;
        cmd_data  = '0;
        req_ack   = 1'b0;
        port_hold = (state_q != ST_IDLE) && (state_q != ST_GAP);
        unique case (state_q)
            ST_HEAD: begin
                if ((head_q || tail_q) && !busy) begin
                    cmd_valid = 1'b1;
                    cmd_data  = head_q ? cur_q[ADDR_W-1:0] : lim_line[ADDR_W-1:0];
                end
            end
            ST_BODY: begin
                if (body_more && !busy) begin
                    cmd_valid = 1'b1;
                    cmd_data  = cur_q[ADDR_W-1:0];
                end
            end
            ST_SYNC_ISSUE: cmd_valid = 1'b1;
            ST_WAY_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_data  = ADDR_W'(WAY_MASK);
            end
            ST_DONE: req_ack = 1'b1;
            default: ;
        endcase
    end

    // next state and working registers
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        cur_d   = cur_q;
        lim_d   = lim_q;
        blk_d   = blk_q;
        head_d  = head_q;
        tail_d  = tail_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    op_d  = req_op;
                    cur_d = start_line;
                    lim_d = {1'b0, req_end};
                    if (req_op != OP_INVAL && whole_hit) begin
                        state_d = ST_WAY_ISSUE;
                    end else if (req_op == OP_INVAL) begin
                        head_d  = start_part;
                        tail_d  = end_part;
                        state_d = ST_HEAD;
                    end else begin
                        state_d = ST_SETUP;
                    end
                end
            end
            ST_HEAD: begin
                if (head_q) begin
                    if (cmd_valid) begin
                        cur_d  = cur_q + LINE_STEP;
                        head_d = 1'b0;
                    end
                end else if (tail_q) begin
                    if (cmd_valid) begin
                        lim_d  = lim_line;
                        tail_d = 1'b0;
                    end
                end else begin
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (cur_q < lim_q) begin
                    blk_d   = chunk_end;
                    state_d = ST_BODY;
                end else begin
                    state_d = ST_DRAIN;
                end
            end
            ST_BODY: begin
                if (body_more) begin
                    if (cmd_valid) cur_d = cur_q + LINE_STEP;
                end else if (blk_q < lim_q) begin
                    state_d = ST_GAP;
                end else begin
                    state_d = ST_DRAIN;
                end
            end
            ST_GAP:        state_d = ST_SETUP;
            ST_DRAIN:      if (!busy) state_d = ST_SYNC_ISSUE;
            ST_SYNC_ISSUE: state_d = ST_SYNC_WAIT;
            ST_SYNC_WAIT:  if (!busy) state_d = ST_DONE;
            ST_WAY_ISSUE:  state_d = ST_WAY_WAIT;
            ST_WAY_WAIT:   if (!busy) state_d = ST_SYNC_ISSUE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/crs_checker.sv
`timescale 1ns/1ps
module crs_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_WAYS   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ack,
    input logic                cmd_valid,
    input logic [2:0]          cmd_kind,
    input logic [ADDR_W-1:0]   cmd_data,
    input logic                port_hold,
    input logic [2:0]          line_busy,
    input logic                sync_busy
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] MASK_DATA = ADDR_W'({NUM_WAYS{1'b1}});

    logic sync_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             sync_seen <= 1'b0;
        else if (req_ack)                       sync_seen <= 1'b0;
        else if (cmd_valid && cmd_kind == 3'd3) sync_seen <= 1'b1;
    end

    assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_line_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind <= 3'd2) |-> !line_busy[cmd_kind[1:0]]);

    assert_line_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind <= 3'd2) |-> (cmd_data[OFS_W-1:0] == '0));

    assert_cmd_owned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> port_hold);

    assert_ways_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind >= 3'd4) |-> (cmd_data == MASK_DATA));

    assert_gap_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(port_hold) && !$past(req_ack)) |=> port_hold);

    assert_sync_before_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (sync_seen && !sync_busy));

endmodule

bind cache_range_seq crs_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .NUM_WAYS   (NUM_WAYS)
) u_crs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ack   (req_ack),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_data  (cmd_data),
    .port_hold (port_hold),
    .line_busy (line_busy),
    .sync_busy (sync_busy)
);

// File: tb/cache_range_seq_bench.sv
`timescale 1ns/1ps
module cache_range_seq_bench;
    localparam int  LINE  = 32;
    localparam int  CHUNK = 128;
    localparam int  CACHE = 1024;
    localparam int  WAYS  = 4;
    localparam longint BASE = 64'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_start = '0;
    logic [31:0] req_end = '0;
    logic        req_ack;
    logic        cmd_valid;
    logic [2:0]  cmd_kind;
    logic [31:0] cmd_data;
    logic        port_hold;
    logic [2:0]  line_busy;
    logic        sync_busy;
    logic [WAYS-1:0] way_busy;

    always #10 clk = ~clk;

    cache_range_seq #(
        .ADDR_W(32), .LINE_BYTES(LINE), .CHUNK_BYTES(CHUNK),
        .CACHE_BYTES(CACHE), .NUM_WAYS(WAYS)
    ) u_cache_range_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_start(req_start), .req_end(req_end), .req_ack(req_ack),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_data(cmd_data),
        .port_hold(port_hold), .line_busy(line_busy), .sync_busy(sync_busy),
        .way_busy(way_busy)
    );

    // controller model: busy rises the cycle after a command, lasts 1..3 cycles
    int     cnt [0:3];
    logic [WAYS-1:0] way_sh;
    int     n = 0;
    int     log_kind [0:1023];
    longint log_addr [0:1023];
    int     cur_lk = 0;
    int     viol_line = 0, viol_sync = 0, viol_ack = 0;

    assign line_busy = {cnt[2] != 0, cnt[1] != 0, cnt[0] != 0};
    assign sync_busy = cnt[3] != 0;
    assign way_busy  = way_sh;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) cnt[i] <= 0;
            way_sh <= '0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (cmd_valid && int'(cmd_kind) == i) cnt[i] <= 1 + (n % 3);
                else if (cnt[i] != 0)                  cnt[i] <= cnt[i] - 1;
            end
            way_sh <= (cmd_valid && cmd_kind >= 3'd4) ? '1 : (way_sh >> 1);
            if (cmd_valid) begin
                log_kind[n % 1024] <= int'(cmd_kind);
                log_addr[n % 1024] <= longint'(cmd_data);
                n <= n + 1;
                if (cmd_kind <= 3'd2 && line_busy[cmd_kind[1:0]]) viol_line <= viol_line + 1;
                if (cmd_kind == 3'd3 && (line_busy[cur_lk] || way_busy != 0)) viol_sync <= viol_sync + 1;
            end
            if (req_ack && sync_busy) viol_ack <= viol_ack + 1;
        end
    end

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected command list computed from the requirements
    int     exp_kind [0:255];
    longint exp_addr [0:255];
    int     exp_n, exp_gaps;
    string  exp_tag;

    task automatic push(input int k, input longint a);
        exp_kind[exp_n] = k;
        exp_addr[exp_n] = a;
        exp_n++;
    endtask

    task automatic walk(input int k, input longint s, input longint e);
        longint c, blk, step;
        c = s;
        while (c < e) begin
            step = (e - c > CHUNK) ? CHUNK : e - c;
            blk  = c + step;
            while (c < blk) begin
                push(k, c);
                c += LINE;
            end
            if (blk < e) exp_gaps++;
        end
    endtask

    task automatic build_exp(input int op, input longint st, input longint en);
        longint s, e;
        int lines0;
        exp_n = 0; exp_gaps = 0;
        s = st & ~longint'(LINE - 1);
        if (op != 0 && en >= st && en - st >= CACHE) begin
            push(op == 1 ? 4 : 5, (64'd1 << WAYS) - 1);
            exp_tag = "R3";
        end else if (op == 0) begin
            e = en;
            if (st % LINE != 0) begin
                push(2, s);
                s += LINE;
            end
            if (en % LINE != 0) begin
                e = en & ~longint'(LINE - 1);
                push(2, e);
            end
            lines0 = exp_n;
            walk(0, s, e);
            exp_tag = (exp_n == lines0) ? "R7" : ((st % LINE != 0) ? "R5" : "R6");
        end else begin
            walk(op == 1 ? 1 : 2, s, en);
            exp_tag = (exp_n == 0) ? "R7" : "R4";
        end
        push(3, 0);
    endtask

    task automatic run_req(input int op, input longint st, input longint en,
                           input bit scramble, input string tag_over);
        int base, lows, cyc, got, vl, vs, va, bad_i;
        string tag;
        build_exp(op, st, en);
        tag = (tag_over != "") ? tag_over : exp_tag;
        base = n; vl = viol_line; vs = viol_sync; va = viol_ack;
        @(negedge clk);
        cur_lk = (op == 0) ? 0 : ((op == 1) ? 1 : 2);
        req_op = op[1:0]; req_start = st[31:0]; req_end = en[31:0]; req_valid = 1'b1;
        lows = 0; cyc = 0;
        forever begin
            @(negedge clk);
            if (req_ack) break;
            if (!port_hold) lows++;
            cyc++;
            if (scramble && cyc == 2) begin
                req_op = 2'd1; req_start = 32'h0; req_end = 32'h7fff_ffff;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ack == 1'b0, "R1", "ack pulse longer than one cycle", req_ack, 0);
        got = n - base;
        chk(got == exp_n, tag, "command count", got, exp_n);
        if (got == exp_n) begin
            bad_i = -1;
            for (int i = 0; i < exp_n; i++)
                if (bad_i < 0 && (log_kind[(base + i) % 1024] != exp_kind[i] ||
                                  log_addr[(base + i) % 1024] != exp_addr[i])) bad_i = i;
            if (bad_i < 0) chk(1'b1, tag, "command list", 0, 0);
            else chk(1'b0, tag, "command list entry",
                     log_kind[(base + bad_i) % 1024] * 64'h1_0000_0000 + log_addr[(base + bad_i) % 1024],
                     exp_kind[bad_i] * 64'h1_0000_0000 + exp_addr[bad_i]);
        end
        chk(lows == exp_gaps, "R9", "port release cycles", lows, exp_gaps);
        chk(viol_line == vl, "R8", "line command under busy", viol_line - vl, 0);
        chk(viol_sync == vs && viol_ack == va, "R10", "sync or ack before drain",
            (viol_sync - vs) + (viol_ack - va), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid == 0 && req_ack == 0, "R1", "reset outputs idle", {cmd_valid, req_ack}, 0);
        chk(port_hold == 0, "R12", "port not held after reset", port_hold, 0);

        for (int op = 0; op < 3; op++)
            for (int so = 0; so < 64; so += 9)
                for (int li = 0; li < 30; li++)
                    run_req(op, BASE + so, BASE + so + li * 37, 0, "");

        for (int op = 1; op < 3; op++) begin
            run_req(op, BASE + 3, BASE + 3 + CACHE - 1, 0, "R3");
            run_req(op, BASE + 3, BASE + 3 + CACHE, 0, "R3");
            run_req(op, BASE, BASE + CACHE + 1, 0, "R3");
            run_req(op, BASE + 100, BASE + 60, 0, "R7");
        end
        run_req(0, BASE, BASE + CACHE, 0, "R6");
        run_req(0, BASE + 100, BASE + 60, 0, "R7");
        run_req(0, BASE + 5, BASE + 20, 0, "R5");
        run_req(3, BASE + 7, BASE + 300, 0, "R11");
        run_req(3, BASE, BASE + CACHE, 0, "R11");
        run_req(0, BASE + 33, BASE + 400, 1, "R2");
        run_req(1, 64'hFFFF_FFC5, 64'hFFFF_FFFF, 0, "R4");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule